// File: doc/BRIEF.md
# Direct-Indexed Next-Hop Table

The block resolves a packet's IPv4 destination address to a next hop in a fixed two-cycle lookup. It uses no match logic. The upper bits of the destination address serve directly as the index of a flat table. Each entry of that table holds a small next-hop identifier. A second, small table turns the identifier into the next-hop MAC address and the egress port.

Longest-prefix behaviour comes from the order in which routes are installed. A route is given as a prefix, a prefix length and an identifier. A hardware fill engine expands the route into the contiguous range of table entries it covers and writes one entry per clock. Software installs routes from the shortest prefix to the longest, so a longer prefix overwrites the entries of every shorter prefix that contains it.

At full size the index is the address shifted right by four bits, which gives `IDX_W` = 28 and /28 granularity. The default build keeps only the top `IDX_W` = 10 bits so that simulation stays small. Identifier 0 means "no route". Lookups continue while a fill is running and read whatever the table holds at that moment.

Top module: `fib_direct`

## Requirements
- R1: Reset clears every index entry to identifier 0. The clear runs as a fill of all 2^IDX_W entries, and `prog_ready` stays low for 2^IDX_W cycles after reset is released. Every next-hop table entry resets to MAC 0 and port 0.
- R2: A lookup uses `lk_addr[31 -: IDX_W]` as the table index.
- R3: A programming command whose `prog_len` is below 2 or above `IDX_W` is ignored. It changes no entry, and `prog_ready` stays high.
- R4: An accepted command of length L fills indices `((prefix & ~M) >> (32-IDX_W))` through `((prefix | M) >> (32-IDX_W))`, where M = (1 << (32-L)) - 1. The fill writes one entry per clock in ascending order, and `prog_ready` is low for exactly as many cycles as there are entries in the range.
- R5: A command is accepted only on a cycle in which `prog_valid` and `prog_ready` are both high. A command presented while `prog_ready` is low is ignored.
- R6: A later fill overwrites the entries of earlier ones. Installing shorter prefixes first therefore yields the longest-prefix answer.
- R7: When `lk_req` is high at a clock edge, `rep_valid` is high after the following edge, which is two edges later. `rep_valid` is low at all other times.
- R8: A lookup returns the table contents as they stand at its request edge. During a fill, an entry that the engine writes on that same edge still returns its old identifier.
- R9: When `nh_we` is high at an edge, the next-hop entry `nh_id` takes `nh_mac` and `nh_port`. A reply carries the MAC and port held by the entry for its identifier.
- R10: `rep_drop` is high in a reply whose identifier is 0 and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_valid | input | 1 | Route command present |
| prog_prefix | input | 32 | Route prefix address |
| prog_len | input | 6 | Route prefix length |
| prog_id | input | ID_W | Next-hop identifier to fill |
| prog_ready | output | 1 | Fill engine idle, command can be taken |
| nh_we | input | 1 | Next-hop table write strobe |
| nh_id | input | ID_W | Next-hop entry to write |
| nh_mac | input | MAC_W | Next-hop MAC address |
| nh_port | input | PORT_W | Egress port |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Destination address to resolve |
| rep_valid | output | 1 | Reply present |
| rep_id | output | ID_W | Resolved next-hop identifier |
| rep_mac | output | MAC_W | Next-hop MAC address |
| rep_port | output | PORT_W | Egress port |
| rep_drop | output | 1 | No route: the frame is to be dropped |

## Verification
Fill-engine state is visible at the ports. A wrong range bound, a skipped step or a stuck busy flag shows up as `prog_ready` rising on the wrong cycle. A wrongly filled entry shows up in the identifier returned by any lookup to that entry, two cycles after the request. Lookups issued while a fill is sweeping past their index show a write-versus-read ordering fault on the very edge where the two meet. A corrupted next-hop entry appears as a wrong MAC or port in the next reply that carries its identifier.

// File: rtl/fib_direct.sv
module fib_direct #(
  parameter int IDX_W  = 10,
  parameter int ID_W   = 4,
  parameter int PORT_W = 3,
  parameter int MAC_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_valid,
  input  logic [31:0]       prog_prefix,
  input  logic [5:0]        prog_len,
  input  logic [ID_W-1:0]   prog_id,
  output logic              prog_ready,
  input  logic              nh_we,
  input  logic [ID_W-1:0]   nh_id,
  input  logic [MAC_W-1:0]  nh_mac,
  input  logic [PORT_W-1:0] nh_port,
  input  logic              lk_req,
  input  logic [31:0]       lk_addr,
  output logic              rep_valid,
  output logic [ID_W-1:0]   rep_id,
  output logic [MAC_W-1:0]  rep_mac,
  output logic [PORT_W-1:0] rep_port,
  output logic              rep_drop
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int NH = 1 << ID_W;
  localparam logic [5:0] MAX_LEN = 6'(IDX_W);

  logic [ID_W-1:0] tbl [DEPTH];
  logic [MAC_W-1:0] nh_mac_t [NH];
  logic [PORT_W-1:0] nh_port_t [NH];

  logic busy;
  logic [IDX_W-1:0] cur, last;
  logic [ID_W-1:0] wid;
  logic v1;
  logic [ID_W-1:0] id1;

  logic [6:0] host_bits;
  logic [31:0] host_mask, lo_full, hi_full;
  logic len_ok;

  assign host_bits = 7'd32 - {1'b0, prog_len};
  assign host_mask = (32'd1 << host_bits) - 32'd1;
  assign lo_full = prog_prefix & ~host_mask;
  assign hi_full = prog_prefix | host_mask;
  assign len_ok = (prog_len >= 6'd2) && (prog_len <= MAX_LEN);
  assign prog_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      cur  <= '0;
      last <= '1;
      wid  <= '0;
    end else if (busy) begin
      if (cur == last) busy <= 1'b0;
      else cur <= cur + 1'b1;
    end else if (prog_valid && len_ok) begin
      busy <= 1'b1;
      cur  <= lo_full[31 -: IDX_W];
      last <= hi_full[31 -: IDX_W];
      wid  <= prog_id;
    end
  end

  always_ff @(posedge clk) begin
    if (busy) tbl[cur] <= wid;
    id1 <= tbl[lk_addr[31 -: IDX_W]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NH; i++) begin
        nh_mac_t[i]  <= '0;
        nh_port_t[i] <= '0;
      end
    end else if (nh_we) begin
      nh_mac_t[nh_id]  <= nh_mac;
      nh_port_t[nh_id] <= nh_port;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      rep_valid <= 1'b0;
      rep_id    <= '0;
      rep_mac   <= '0;
      rep_port  <= '0;
      rep_drop  <= 1'b0;
    end else begin
      v1        <= lk_req;
      rep_valid <= v1;
      rep_id    <= id1;
      rep_mac   <= nh_mac_t[id1];
      rep_port  <= nh_port_t[id1];
      rep_drop  <= (id1 == '0);
    end
  end
endmodule

// File: rtl/fib_direct_chk.sv
module fib_direct_chk #(
  parameter int IDX_W = 10,
  parameter int ID_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog_valid,
  input logic [5:0]       prog_len,
  input logic             lk_req,
  input logic             rep_valid,
  input logic [ID_W-1:0]  rep_id,
  input logic             rep_drop,
  input logic             busy,
  input logic [IDX_W-1:0] cur,
  input logic [IDX_W-1:0] last,
  input logic [ID_W-1:0]  wid
);
  localparam logic [5:0] MAX_LEN = 6'(IDX_W);

  // R7
  reply_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> ##1 rep_valid);

  // R7
  no_spurious_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> ##1 !rep_valid);

  // R4
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur != last) |=> (busy && cur == $past(cur) + 1'b1));

  // R4
  fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur == last) |=> !busy);

  // R3
  bad_len_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && prog_valid && (prog_len < 6'd2 || prog_len > MAX_LEN)) |=> !busy);

  // R5
  busy_holds_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur != last) |=> ($stable(wid) && $stable(last)));

  // R10
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> (rep_drop == (rep_id == '0)));
endmodule

bind fib_direct fib_direct_chk #(.IDX_W(IDX_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/fib_direct_test.sv
module fib_direct_test;
  localparam int IDX_W = 10, ID_W = 4, PORT_W = 3, MAC_W = 48;
  localparam int DEPTH = 1 << IDX_W;
  localparam int SHIFT = 32 - IDX_W;

  logic clk = 0, rst_n = 0;
  logic prog_valid = 0;
  logic [31:0] prog_prefix = '0;
  logic [5:0] prog_len = '0;
  logic [ID_W-1:0] prog_id = '0;
  logic prog_ready;
  logic nh_we = 0;
  logic [ID_W-1:0] nh_id = '0;
  logic [MAC_W-1:0] nh_mac = '0;
  logic [PORT_W-1:0] nh_port = '0;
  logic lk_req = 0;
  logic [31:0] lk_addr = '0;
  logic rep_valid, rep_drop;
  logic [ID_W-1:0] rep_id;
  logic [MAC_W-1:0] rep_mac;
  logic [PORT_W-1:0] rep_port;

  fib_direct #(.IDX_W(IDX_W), .ID_W(ID_W), .PORT_W(PORT_W), .MAC_W(MAC_W)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [ID_W-1:0] m_tbl [DEPTH];
  logic [MAC_W-1:0] m_mac [16];
  logic [PORT_W-1:0] m_port [16];
  bit m_busy, m_v1, e_valid;
  int m_cur, m_last;
  logic [ID_W-1:0] m_wid, m_id1, e_id;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1; m_cur = 0; m_last = DEPTH - 1; m_wid = 0;
      m_v1 = 0; e_valid = 0; e_id = 0;
      for (int i = 0; i < 16; i++) begin m_mac[i] = 0; m_port[i] = 0; end
    end else begin
      e_valid = m_v1;
      e_id = m_id1;
      m_v1 = lk_req;
      m_id1 = m_tbl[lk_addr >> SHIFT];
      if (m_busy) begin
        m_tbl[m_cur] = m_wid;
        if (m_cur == m_last) m_busy = 0;
        else m_cur++;
      end else if (prog_valid && prog_len >= 2 && prog_len <= IDX_W) begin
        logic [31:0] hm;
        hm = (32'd1 << (32 - prog_len)) - 32'd1;
        m_cur = int'((prog_prefix & ~hm) >> SHIFT);
        m_last = int'((prog_prefix | hm) >> SHIFT);
        m_wid = prog_id;
        m_busy = 1;
      end
      if (nh_we) begin m_mac[nh_id] = nh_mac; m_port[nh_id] = nh_port; end
    end
    #5;
    if (!done) begin
      chk(prog_ready == !m_busy, "R1/R4/R5 prog_ready", prog_ready, !m_busy);
      chk(rep_valid == e_valid, "R7 rep_valid", rep_valid, e_valid);
      if (e_valid) begin
        chk(rep_id == e_id, "R8 rep_id", rep_id, e_id);
        chk(rep_mac == m_mac[e_id] && rep_port == m_port[e_id], "R9 next hop",
            {rep_port, rep_mac}, {m_port[e_id], m_mac[e_id]});
        chk(rep_drop == (e_id == 0), "R10 rep_drop", rep_drop, e_id == 0);
      end
    end
  end

  task automatic prog(input logic [31:0] p, input logic [5:0] l, input logic [ID_W-1:0] id);
    @(negedge clk);
    prog_valid = 1; prog_prefix = p; prog_len = l; prog_id = id;
    @(negedge clk);
    prog_valid = 0;
  endtask

  task automatic wait_idle();
    while (!prog_ready) @(negedge clk);
  endtask

  task automatic look(input logic [31:0] a, input logic [ID_W-1:0] exp_id, input string req);
    @(negedge clk);
    lk_req = 1; lk_addr = a;
    @(negedge clk);
    lk_req = 0;
    @(posedge clk); #5;
    chk(rep_valid && rep_id == exp_id, req, rep_id, exp_id);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: clear lasts DEPTH cycles
    n = 0;
    while (!prog_ready) begin @(negedge clk); n++; end
    chk(n == DEPTH, "R1 clear length", n, DEPTH);
    look(32'h0A00_0000, 0, "R1 R10 empty table");
    @(negedge clk);
    nh_we = 1; nh_id = 1; nh_mac = 48'h0200_0000_0011; nh_port = 1;
    @(negedge clk);
    nh_id = 2; nh_mac = 48'h0200_0000_0022; nh_port = 2;
    @(negedge clk);
    nh_id = 3; nh_mac = 48'h0200_0000_0033; nh_port = 5;
    @(negedge clk);
    nh_we = 0;
    // R4 R8: /2 fill with lookups racing the sweep
    prog(32'h4000_0000, 6'd2, 1);
    lk_req = 1; lk_addr = 32'h4000_0000;
    repeat (3) @(negedge clk);
    lk_addr = 32'h7FC0_0000;
    // R5: command during fill ignored
    prog_valid = 1; prog_prefix = 32'hC000_0000; prog_len = 6'd4; prog_id = 3;
    @(negedge clk);
    prog_valid = 0; lk_req = 0;
    n = 0;
    while (!prog_ready) begin @(negedge clk); n++; end
    chk(n == 256 - 4, "R4 fill length", n, 252);
    // R3: bad lengths ignored
    prog(32'h8000_0000, 6'd1, 2);
    prog(32'h8000_0000, 6'd11, 2);
    wait_idle();
    // R6: longer prefixes overwrite
    prog(32'h4000_0000, 6'd8, 2);
    wait_idle();
    prog(32'h4140_0000, 6'd10, 3);
    wait_idle();
    look(32'h4001_0203, 2, "R6 /8 over /2");
    look(32'h4150_0000, 3, "R6 R2 /10 over /2");
    look(32'h4100_0000, 1, "R2 R6 /2 only");
    look(32'h7FFF_FFFF, 1, "R4 range top");
    look(32'h3FFF_FFFF, 0, "R4 below range");
    look(32'h8000_0000, 0, "R3 bad length ignored");
    look(32'hC000_0001, 0, "R5 busy command ignored");
    @(posedge clk); #5;
    chk(rep_mac == 48'h0 || !rep_valid, "R7 idle reply", rep_valid, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule